// File: doc/BRIEF.md
# Triple-Redundant Strap Majority Reader

This block produces a read-only 32-bit strap word that is never kept anywhere as a single copy. Three copies of the word sit at the start of a byte-wide fuse array. When `fetch_req` is seen, the block reads array bytes 0 to 11 one after another over a byte read port. It assembles the three copies as little-endian words and forms each result bit by a two-of-three vote across the copies. The voted word goes into a result register. That register can be read at offset 0x10 of a word-wide register port, and it also drives a dedicated output.

`strap_valid` rises once a fetch has voted its result. It drops when a new fetch is accepted. While that fetch runs, the previous value stays readable. A request that arrives during a fetch is dropped. Writes on the register port change nothing.

Top module: `strap_majority_reader`

## Requirements
- R1: A fetch drives `mem_rd_en` high for exactly 12 cycles, one after another. During those cycles `mem_addr` takes the values 0, 1, …, 11 in that order.
- R2: Copy c (c = 0, 1, 2) is built from array bytes 4c to 4c+3. The byte at address 4c+b lands in result bits 8b+7 down to 8b, which is little-endian order.
- R3: Result bit i is 1 exactly when at least two of the three copies have bit i set.
- R4: `mem_rdata` must carry the byte addressed in the previous cycle. The voted value shows on `strap_value`, and `strap_valid` is high, 14 rising edges after the edge that samples `fetch_req` high.
- R5: At the edge that accepts a new fetch, `strap_valid` goes low. `strap_value` keeps its previous result until the new vote lands.
- R6: While a fetch is in progress, `fetch_req` is ignored. The running fetch neither restarts nor finishes later, and it still issues exactly 12 reads.
- R7: A read with `bus_addr` equal to 0x10 returns `strap_value` on `bus_rdata` in the same cycle. Every other offset reads as 0.
- R8: A write at any offset, including 0x10, has no effect on `strap_value`, `strap_valid` or any read value.
- R9: After reset, `strap_value` is 0, `strap_valid` is 0 and `mem_rd_en` is 0 until the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_req | input | 1 | Start a fetch and vote; ignored while one is running |
| mem_rd_en | output | 1 | Fuse array byte read strobe |
| mem_addr | output | 10 | Fuse array byte address |
| mem_rdata | input | 8 | Array byte, one cycle after its address |
| bus_addr | input | 12 | Register port byte offset |
| bus_wr_en | input | 1 | Register write strobe (discarded) |
| bus_wdata | input | 32 | Register write data (discarded) |
| bus_rdata | output | 32 | Register read data |
| strap_value | output | 32 | Voted strap word |
| strap_valid | output | 1 | Voted word is current |

## Verification
The address sequence is due one edge after the request edge and lasts 12 cycles. The cleared valid is due one edge after the request edge. The voted word and the rising valid are due 14 edges after the request edge. A register read answers within the same cycle.

The driver records the number of the edge that samples each request and pushes the expected word into a queue. The monitor samples on falling edges. It checks the exact edge distance when valid rises, and it follows each read address as it appears. A second request sent partway through a fetch must leave that distance at 14 and the read count at 12.

// File: rtl/strap_pkg.sv
package strap_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_RUN  = 2'd1,
        FS_DONE = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/strap_fetch_seq.sv
module strap_fetch_seq
    import strap_pkg::*;
#(
    parameter int unsigned STRAP_W = 32,
    parameter int unsigned COPIES  = 3,
    parameter int unsigned MEM_AW  = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fetch_req,
    output logic                          mem_rd_en,
    output logic [MEM_AW-1:0]             mem_addr,
    input  logic [BYTE_W-1:0]             mem_rdata,
    output logic                          fetch_start,
    output logic                          fetch_done,
    output logic [COPIES*STRAP_W-1:0]     fetch_bytes
);
    localparam int unsigned BPC    = STRAP_W / BYTE_W;
    localparam int unsigned NBYTES = COPIES * BPC;
    localparam int unsigned CW     = $clog2(NBYTES + 1);

    typedef struct packed {
        fetch_state_e              state;
        logic [CW-1:0]             issue_cnt;
        logic [CW-1:0]             cap_cnt;
        logic                      rvalid;
        logic [NBYTES*BYTE_W-1:0]  bytes;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        fetch_start = 1'b0;
        fetch_done  = 1'b0;
        mem_rd_en   = (seq_q.state == FS_RUN) && (seq_q.issue_cnt < CW'(NBYTES));
        seq_d.rvalid = mem_rd_en;
        case (seq_q.state)
            FS_IDLE: begin
                if (fetch_req) begin
                    seq_d.state     = FS_RUN;
                    seq_d.issue_cnt = '0;
                    seq_d.cap_cnt   = '0;
                    fetch_start     = 1'b1;
                end
            end
            FS_RUN: begin
                if (mem_rd_en) begin
                    seq_d.issue_cnt = seq_q.issue_cnt + 1'b1;
                end
                if (seq_q.rvalid) begin
                    seq_d.bytes[int'(seq_q.cap_cnt)*BYTE_W +: BYTE_W] = mem_rdata;
                    seq_d.cap_cnt = seq_q.cap_cnt + 1'b1;
                    if (seq_q.cap_cnt == CW'(NBYTES - 1)) begin
                        seq_d.state = FS_DONE;
                    end
                end
            end
            FS_DONE: begin
                fetch_done  = 1'b1;
                seq_d.state = FS_IDLE;
            end
            default: seq_d.state = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mem_addr    = MEM_AW'(seq_q.issue_cnt);
    assign fetch_bytes = seq_q.bytes;

    assert_addr_ascending_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    assert_addr_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (int'(mem_addr) < NBYTES));

    assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && seq_q.state == FS_RUN) |=> (seq_q.cap_cnt >= $past(seq_q.cap_cnt)));

    assert_done_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |-> (seq_q.cap_cnt == CW'(NBYTES)));
endmodule

// File: rtl/strap_vote.sv
module strap_vote #(
    parameter int unsigned STRAP_W = 32,
    parameter int unsigned COPIES  = 3
) (
    input  logic [COPIES*STRAP_W-1:0] copies_flat,
    output logic [STRAP_W-1:0]        vote
);
    localparam int unsigned NW   = $clog2(COPIES + 1);
    localparam int unsigned HALF = COPIES / 2;

    for (genvar b = 0; b < STRAP_W; b++) begin : g_bit
        logic [NW-1:0] ones;
        always_comb begin
            ones = '0;
            for (int c = 0; c < COPIES; c++) begin
                ones = ones + NW'(copies_flat[c*STRAP_W + b]);
            end
        end
        assign vote[b] = (int'(ones) > HALF);
    end
endmodule

// File: rtl/strap_regif.sv
module strap_regif #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned STRAP_W   = 32,
    parameter int unsigned STRAP_OFS = 16
) (
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr_en,
    input  logic [STRAP_W-1:0] bus_wdata,
    input  logic [STRAP_W-1:0] strap_value,
    output logic [STRAP_W-1:0] bus_rdata
);
    logic wr_sink_unused;

    // The strap offset is read-only and no other register lives here,
    // so write traffic is deliberately dropped.
    assign wr_sink_unused = bus_wr_en ^ (^bus_wdata);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(STRAP_OFS)) begin
            bus_rdata = strap_value;
        end
    end
endmodule

// File: rtl/strap_majority_reader.sv
module strap_majority_reader
    import strap_pkg::*;
#(
    parameter int unsigned STRAP_W   = 32,
    parameter int unsigned COPIES    = 3,
    parameter int unsigned MEM_AW    = 10,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned STRAP_OFS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fetch_req,
    output logic               mem_rd_en,
    output logic [MEM_AW-1:0]  mem_addr,
    input  logic [7:0]         mem_rdata,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr_en,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [31:0]        strap_value,
    output logic               strap_valid
);
    logic                        fetch_start;
    logic                        fetch_done;
    logic [COPIES*STRAP_W-1:0]   fetch_bytes;
    logic [STRAP_W-1:0]          voted;

    typedef struct packed {
        logic [STRAP_W-1:0] strap;
        logic               valid;
    } res_t;

    res_t res_d, res_q;

    strap_fetch_seq #(
        .STRAP_W (STRAP_W),
        .COPIES  (COPIES),
        .MEM_AW  (MEM_AW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_req   (fetch_req),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .mem_rdata   (mem_rdata),
        .fetch_start (fetch_start),
        .fetch_done  (fetch_done),
        .fetch_bytes (fetch_bytes)
    );

    strap_vote #(
        .STRAP_W (STRAP_W),
        .COPIES  (COPIES)
    ) u_vote (
        .copies_flat (fetch_bytes),
        .vote        (voted)
    );

    strap_regif #(
        .ADDR_W    (ADDR_W),
        .STRAP_W   (STRAP_W),
        .STRAP_OFS (STRAP_OFS)
    ) u_regif (
        .bus_addr    (bus_addr),
        .bus_wr_en   (bus_wr_en),
        .bus_wdata   (bus_wdata),
        .strap_value (res_q.strap),
        .bus_rdata   (bus_rdata)
    );

    always_comb begin
        res_d = res_q;
        if (fetch_start) begin
            res_d.valid = 1'b0;
        end
        if (fetch_done) begin
            res_d.strap = voted;
            res_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign strap_value = res_q.strap;
    assign strap_valid = res_q.valid;

    // Bounds every vote must respect: bits common to all copies survive,
    // bits absent from all copies never appear.
    logic [STRAP_W-1:0] chk_and, chk_or;
    always_comb begin
        chk_and = '1;
        chk_or  = '0;
        for (int c = 0; c < COPIES; c++) begin
            chk_and = chk_and & fetch_bytes[c*STRAP_W +: STRAP_W];
            chk_or  = chk_or  | fetch_bytes[c*STRAP_W +: STRAP_W];
        end
    end

    assert_vote_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |-> (((chk_and & ~voted) == '0) && ((voted & ~chk_or) == '0)));

    assert_valid_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strap_valid) |-> $past(fetch_done));

    assert_value_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fetch_done) |-> $stable(strap_value));

    assert_write_no_effect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && !fetch_done) |=> $stable(strap_value));

    assert_bus_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(STRAP_OFS)) |-> (bus_rdata == strap_value));

    assert_bus_other_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != ADDR_W'(STRAP_OFS)) |-> (bus_rdata == '0));
endmodule

// File: tb/strap_majority_reader_tb.sv
`timescale 1ns/1ps
module strap_majority_reader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0;
    logic        mem_rd_en;
    logic [9:0]  mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic [11:0] bus_addr = 12'h010;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [31:0] strap_value;
    logic        strap_valid;

    always #2.5 clk = ~clk;

    strap_majority_reader u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_req   (fetch_req),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .mem_rdata   (mem_rdata),
        .bus_addr    (bus_addr),
        .bus_wr_en   (bus_wr_en),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .strap_value (strap_value),
        .strap_valid (strap_valid)
    );

    // Byte array model with one cycle of read latency.
    logic [7:0] mem [0:15];
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr[3:0]];
    end

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [31:0] last_val = 32'h0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [31:0] val;
        int          req_edge;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] maj(logic [31:0] a, logic [31:0] b, logic [31:0] c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    task automatic load(logic [31:0] w0, logic [31:0] w1, logic [31:0] w2);
        for (int b = 0; b < 4; b++) begin
            mem[b]     = w0[8*b +: 8];
            mem[4 + b] = w1[8*b +: 8];
            mem[8 + b] = w2[8*b +: 8];
        end
        for (int b = 12; b < 16; b++) mem[b] = 8'hA5;
    endtask

    // Driver: issue a request, push expectation, optionally poke mid-fetch.
    task automatic run_fetch(logic [31:0] w0, logic [31:0] w1, logic [31:0] w2,
                             string tag, bit poke);
        exp_t e;
        load(w0, w1, w2);
        e.val = maj(w0, w1, w2);
        e.tag = tag;
        @(negedge clk);
        fetch_req = 1'b1;
        e.req_edge = cyc + 1;
        sbq.push_back(e);
        @(negedge clk);
        fetch_req = 1'b0;
        chk("R5 valid low after accept", {31'h0, strap_valid}, 32'h0);
        chk("R5 previous value held", strap_value, last_val);
        if (poke) begin
            repeat (4) @(negedge clk);
            fetch_req = 1'b1;
            @(negedge clk);
            fetch_req = 1'b0;
        end
        while (sbq.size() != 0) @(negedge clk);
        last_val = e.val;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: follows read addresses and compares results as they land.
    int exp_addr = 0;
    logic prev_valid = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd_en) begin
                chk("R1 read address order", {22'h0, mem_addr}, exp_addr);
                exp_addr++;
            end
            if (strap_valid && !prev_valid) begin
                if (sbq.size() == 0) begin
                    chk("R4 unexpected completion", 32'h1, 32'h0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(e.tag, strap_value, e.val);
                    chk("R4 edges from request", cyc - e.req_edge, 32'd14);
                    chk("R1 R6 read count", exp_addr, 32'd12);
                    chk("R7 bus read at 0x10", bus_rdata, e.val);
                end
                exp_addr = 0;
            end
            prev_valid = strap_valid;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        load(32'h0, 32'h0, 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 strap_value after reset", strap_value, 32'h0);
        chk("R9 strap_valid after reset", {31'h0, strap_valid}, 32'h0);
        chk("R9 no reads after reset", {31'h0, mem_rd_en}, 32'h0);
        chk("R9 bus read after reset", bus_rdata, 32'h0);

        // R2 little-endian assembly: identical copies with distinct bytes
        run_fetch(32'h1234_5678, 32'h1234_5678, 32'h1234_5678, "R2 byte order", 1'b0);
        // R3 voting patterns
        run_fetch(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 all ones", 1'b0);
        run_fetch(32'hF0F0_F0F0, 32'hCCCC_CCCC, 32'hAAAA_AAAA, "R3 mixed vote", 1'b0);
        run_fetch(32'hDEAD_BEEF, 32'h0000_0000, 32'hDEAD_BEEF, "R3 middle copy wrong", 1'b0);
        run_fetch(32'h8000_0001, 32'h8000_0001, 32'h0000_0000, "R3 last copy wrong", 1'b0);
        // R6 request during a fetch
        run_fetch(32'h0F1E_2D3C, 32'h4B5A_6978, 32'h0F1E_2D3C, "R6 mid-fetch request", 1'b1);

        // R7 other offsets read zero
        bus_addr = 12'h000; #1;
        chk("R7 offset 0x000 reads zero", bus_rdata, 32'h0);
        bus_addr = 12'h014; #1;
        chk("R7 offset 0x014 reads zero", bus_rdata, 32'h0);
        bus_addr = 12'h011; #1;
        chk("R7 offset 0x011 reads zero", bus_rdata, 32'h0);

        // R8 writes have no effect
        @(negedge clk);
        bus_addr = 12'h010; bus_wdata = 32'h5555_AAAA; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_addr = 12'h00C; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_addr = 12'h010;
        @(negedge clk);
        chk("R8 strap after writes", strap_value, last_val);
        chk("R8 bus read after writes", bus_rdata, last_val);
        chk("R8 valid after writes", {31'h0, strap_valid}, 32'h1);
        bus_addr = 12'h00C; #1;
        chk("R8 written offset still zero", bus_rdata, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule